// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block is the transmit half of an asynchronous serial link. It runs from a clock at sixteen times the bit rate, so each clock cycle is one tick and a normal bit lasts sixteen ticks. A rising edge on the data strobe captures an 8-bit character into a holding register. When the output shifter is free, the character moves into it on the next tick and the holding register becomes free again. A second character can therefore wait in the holding register while the first one is being sent.

Each frame has one low start bit, then 5 to 8 data bits sent least significant first. An optional parity bit comes next, followed by one, one-and-a-half or two high stop bits. A format register holds the frame shape and is loaded while the control strobe is high. Tying that strobe high makes the register follow its inputs with one tick of delay. Two flags report progress: one shows that the holding register can take a character, and the other shows that the last frame has finished and the line is idle.

Top module: `sertx`

## Requirements
- R1: While reset is high and on the first tick after it, the serial output is 1, the buffer-free flag is 1 and the frame-done flag is 1.
- R2: A data strobe sampled at 1 on a clock edge, after being sampled at 0 on the previous edge, captures the data inputs into the holding register. The buffer-free flag is 0 after that edge. Keeping the strobe high captures nothing more and sends nothing more.
- R3: If the shifter is idle when the holding register is full, then on the next edge the character moves into the shifter. From that tick onward the buffer-free flag is 1, the frame-done flag is 0 and the serial output carries the start bit (0).
- R4: Every start, data and parity bit lasts exactly 16 ticks. The data bits follow the start bit least significant first. The length field selects how many low bits are sent: 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, and higher input bits are not sent.
- R5: When the no-parity field is 0, one parity bit follows the last data bit. With the parity-select field at 1 the data and parity bits hold an even number of ones, and at 0 an odd number. When the no-parity field is 1, the stop bits follow the data at once.
- R6: With the stop field at 0 the stop time is 16 ticks of 1. With the stop field at 1 it is 32 ticks, except for 5-bit characters, where it is 24 ticks.
- R7: On the tick after the last stop tick, the frame-done flag is 1 if no character is waiting. It then stays 1, with the serial output at 1, until the next frame starts.
- R8: A character captured while a frame is in progress waits with the buffer-free flag at 0. Its start bit begins on the tick right after the previous frame's last stop tick, with no idle tick in between, and the frame-done flag stays 0 across that boundary.
- R9: The format fields are captured on each edge where the control strobe is 1. While the strobe is 0, changes on the format inputs do not affect later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Character to send |
| data_stb | input | 1 | Data strobe; its rising edge captures data_in |
| ctl_stb | input | 1 | Control strobe; format fields are captured while it is 1 |
| fmt_even | input | 1 | Parity select: 1 gives even parity, 0 gives odd parity |
| fmt_nopar | input | 1 | 1 removes the parity bit |
| fmt_twostop | input | 1 | 0 gives one stop bit; 1 gives two (1.5 for 5-bit characters) |
| fmt_len | input | 2 | Data length: 0 to 3 select 5 to 8 bits |
| ser_out | output | 1 | Serial line, high when idle |
| buf_empty | output | 1 | Holding register can accept a character |
| char_done | output | 1 | Last frame has ended and no frame is running |

## Verification
A wrong tick phase or a wrong remaining-tick count shows on the serial line within one bit time. It appears as a bit edge that is off by a tick or as a stop period of the wrong length, so the bench compares every tick of every frame. A wrong holding-register state shows on the buffer-free flag one tick after a strobe or a transfer. It also shows as a missing, duplicated or delayed back-to-back frame at the next frame boundary. A wrong format register shows in the first frame sent after the control strobe, as the wrong bit count, parity value or stop length.

// File: rtl/sertx.sv
module sertx #(
  parameter int TICKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] data_in,
  input  logic       data_stb,
  input  logic       ctl_stb,
  input  logic       fmt_even,
  input  logic       fmt_nopar,
  input  logic       fmt_twostop,
  input  logic [1:0] fmt_len,
  output logic       ser_out,
  output logic       buf_empty,
  output logic       char_done
);
  localparam int PW = $clog2(TICKS);
  localparam int FW = 12;
  localparam int CW = $clog2(10 * TICKS + 2 * TICKS + 1);

  logic          stb_q;
  logic [7:0]    hold;
  logic [1:0]    f_len;
  logic          f_even, f_nopar, f_two;
  logic          busy;
  logic [PW-1:0] phase;
  logic [CW-1:0] remain;
  logic [FW-1:0] sreg;
  logic [FW-1:0] frame;
  logic [3:0]    dlen;
  logic [3:0]    nslots;
  logic [7:0]    dmask;
  logic          par_bit;
  logic          load, start;
  int            stop_t;
  logic [CW-1:0] total;

  assign dlen    = 4'd5 + {2'b00, f_len};
  assign dmask   = 8'hFF >> (2'd3 - f_len);
  assign par_bit = ^(hold & dmask) ^ ~f_even;
  assign nslots  = dlen + 4'd1 + {3'b000, ~f_nopar};
  assign stop_t  = f_two ? ((f_len == 2'd0) ? (3 * TICKS) / 2 : 2 * TICKS) : TICKS;
  assign total   = CW'(int'(nslots) * TICKS + stop_t);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(dlen)) frame[i+1] = hold[i];
    if (!f_nopar) frame[dlen + 4'd1] = par_bit;
  end

  assign load    = data_stb & ~stb_q;
  assign start   = ~buf_empty & (~busy | (remain == CW'(1)));
  assign ser_out = busy ? sreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q     <= 1'b0;
      hold      <= '0;
      buf_empty <= 1'b1;
      char_done <= 1'b1;
      busy      <= 1'b0;
      phase     <= '0;
      remain    <= '0;
      sreg      <= '1;
      f_len     <= '0;
      f_even    <= 1'b0;
      f_nopar   <= 1'b0;
      f_two     <= 1'b0;
    end else begin
      stb_q <= data_stb;
      if (ctl_stb) begin
        f_len   <= fmt_len;
        f_even  <= fmt_even;
        f_nopar <= fmt_nopar;
        f_two   <= fmt_twostop;
      end
      if (start) begin
        busy      <= 1'b1;
        sreg      <= frame;
        remain    <= total;
        phase     <= '0;
        buf_empty <= 1'b1;
        char_done <= 1'b0;
      end else if (busy) begin
        phase  <= (phase == PW'(TICKS - 1)) ? '0 : phase + 1'b1;
        if (phase == PW'(TICKS - 1)) sreg <= {1'b1, sreg[FW-1:1]};
        remain <= remain - 1'b1;
        if (remain == CW'(1)) begin
          busy      <= 1'b0;
          char_done <= 1'b1;
        end
      end
      if (load) begin
        hold      <= data_in;
        buf_empty <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          data_stb,
  input logic          ser_out,
  input logic          buf_empty,
  input logic          char_done,
  input logic          busy,
  input logic [PW-1:0] phase
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ser_out && buf_empty && char_done));

  assert_strobe_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (data_stb && !$past(data_stb) && !$past(rst)) |=> !buf_empty);

  assert_idle_start_R3: assert property (@(posedge clk) disable iff (rst)
    (!buf_empty && char_done) |=> (!char_done && !ser_out));

  assert_bit_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && phase != '0) |-> $stable(ser_out));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    char_done |-> ser_out);

  assert_start_needs_char_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(char_done) |-> !$past(buf_empty));
endmodule

bind sertx sertx_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .data_stb(data_stb), .ser_out(ser_out),
  .buf_empty(buf_empty), .char_done(char_done), .busy(busy), .phase(phase)
);

// File: tb/sertx_bench.sv
module sertx_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in = '0;
  logic       data_stb = 1'b0;
  logic       ctl_stb = 1'b0;
  logic       fmt_even = 1'b0;
  logic       fmt_nopar = 1'b0;
  logic       fmt_twostop = 1'b0;
  logic [1:0] fmt_len = '0;
  logic       ser_out, buf_empty, char_done;

  int  total_n = 0;
  int  bad_n = 0;
  bit  done = 0;
  logic cap [0:511];

  int  e_len = 5;
  bit  e_par = 1, e_even = 0, e_two = 0;

  sertx u_sertx (
    .clk(clk), .rst(rst), .data_in(data_in), .data_stb(data_stb),
    .ctl_stb(ctl_stb), .fmt_even(fmt_even), .fmt_nopar(fmt_nopar),
    .fmt_twostop(fmt_twostop), .fmt_len(fmt_len), .ser_out(ser_out),
    .buf_empty(buf_empty), .char_done(char_done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int frame_len();
    return (1 + e_len + (e_par ? 1 : 0)) * 16 + (e_two ? ((e_len == 5) ? 24 : 32) : 16);
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input int t);
    int slot = t / 16;
    logic p = e_even ? 1'b0 : 1'b1;
    for (int i = 0; i < e_len; i++) p ^= d[i];
    if (t >= (1 + e_len + (e_par ? 1 : 0)) * 16) return 1'b1;
    if (slot == 0) return 1'b0;
    if (slot <= e_len) return d[slot-1];
    return p;
  endfunction

  task automatic grab(input int off, input int n);
    for (int t = 0; t < n; t++) begin
      cap[off + t] = ser_out;
      @(negedge clk);
    end
  endtask

  task automatic cmp_frame(input logic [7:0] d, input int off, input string tag);
    int n = frame_len();
    int mism = 0;
    for (int t = 0; t < n; t++) if (cap[off + t] !== exp_bit(d, t)) mism++;
    chk(mism == 0, tag, mism, 0);
  endtask

  task automatic set_fmt(input int len, input bit par, input bit even, input bit two);
    @(negedge clk);
    fmt_len = 2'(len - 5); fmt_nopar = ~par; fmt_even = even; fmt_twostop = two;
    ctl_stb = 1'b1;
    @(negedge clk);
    ctl_stb = 1'b0;
    fmt_len = ~fmt_len; fmt_nopar = ~fmt_nopar; fmt_even = ~fmt_even; fmt_twostop = ~fmt_twostop;
    e_len = len; e_par = par; e_even = even; e_two = two;
  endtask

  task automatic send_one(input logic [7:0] d, input string tag);
    int n;
    @(negedge clk);
    data_in = d; data_stb = 1'b1;
    @(negedge clk);
    data_stb = 1'b0;
    chk(buf_empty == 1'b0, "R2 buffer filled by strobe", buf_empty, 0);
    @(negedge clk);
    chk(buf_empty && !char_done && !ser_out, "R3 transfer on next tick",
        {buf_empty, char_done, ser_out}, 3'b100);
    n = frame_len();
    grab(0, n + 1);
    cmp_frame(d, 0, tag);
    chk(cap[n] == 1'b1 && char_done == 1'b1, "R7 idle after frame",
        {cap[n], char_done}, 2'b11);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ser_out && buf_empty && char_done, "R1 reset state",
        {ser_out, buf_empty, char_done}, 3'b111);
    rst = 1'b0;
    @(negedge clk);
    chk(ser_out && buf_empty && char_done, "R1 after reset release",
        {ser_out, buf_empty, char_done}, 3'b111);
  endtask

  task automatic t_basic;
    set_fmt(8, 0, 0, 0);
    send_one(8'hA5, "R4 8-bit no parity one stop");
    send_one(8'h3C, "R4 8-bit second pattern");
  endtask

  task automatic t_parity;
    set_fmt(7, 1, 1, 1);
    send_one(8'h2B, "R5 7-bit even parity two stop R6");
    set_fmt(8, 1, 0, 0);
    send_one(8'h81, "R5 8-bit odd parity");
  endtask

  task automatic t_half_stop;
    set_fmt(5, 1, 0, 1);
    send_one(8'h13, "R6 5-bit 1.5 stop");
  endtask

  task automatic t_mask;
    set_fmt(6, 0, 0, 0);
    send_one(8'hED, "R4 6-bit upper bits dropped");
  endtask

  task automatic t_ctl_hold;
    set_fmt(6, 1, 1, 0);
    @(negedge clk);
    fmt_len = 2'd3; fmt_nopar = 1'b1; fmt_even = 1'b0; fmt_twostop = 1'b1;
    send_one(8'h35, "R9 format inputs ignored without strobe");
  endtask

  task automatic t_held_strobe;
    int n, bad;
    set_fmt(8, 0, 0, 0);
    @(negedge clk);
    data_in = 8'h5A; data_stb = 1'b1;
    @(negedge clk);
    chk(buf_empty == 1'b0, "R2 held strobe first capture", buf_empty, 0);
    @(negedge clk);
    n = frame_len();
    grab(0, n);
    cmp_frame(8'h5A, 0, "R2 held strobe frame");
    bad = 0;
    for (int t = 0; t < 40; t++) begin
      if (!(ser_out && char_done && buf_empty)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R2 held strobe sends once", bad, 0);
    data_stb = 1'b0;
  endtask

  task automatic t_back2back;
    int n;
    set_fmt(7, 1, 0, 0);
    n = frame_len();
    @(negedge clk);
    data_in = 8'h4E; data_stb = 1'b1;
    @(negedge clk);
    data_stb = 1'b0;
    @(negedge clk);
    for (int t = 0; t < 2 * n + 1; t++) begin
      cap[t] = ser_out;
      if (t == 21) chk(buf_empty == 1'b0, "R8 second char waits", buf_empty, 0);
      if (t == n - 1) chk(buf_empty == 1'b0, "R8 still waiting at last stop tick", buf_empty, 0);
      if (t == n) chk(buf_empty && !char_done, "R8 gapless handover",
                      {buf_empty, char_done}, 2'b10);
      if (t == 20) begin data_in = 8'h71; data_stb = 1'b1; end
      if (t == 21) data_stb = 1'b0;
      @(negedge clk);
    end
    cmp_frame(8'h4E, 0, "R8 first frame");
    cmp_frame(8'h71, n, "R8 second frame");
    chk(cap[2*n] == 1'b1 && char_done, "R7 done after pair", {cap[2*n], char_done}, 2'b11);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total_n++; bad_n++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_half_stop();
    t_mask();
    t_ctl_hold();
    t_held_strobe();
    t_back2back();
    finish_up();
  end
endmodule